// File: doc/BRIEF.md
# Vectored Interrupt Controller Core

This block gathers up to eight level-sensitive interrupt request lines and drives one interrupt line to a processor. Each input is captured into a request register every cycle. An input is passed on only when its mask bit is clear. Among the requests that remain, the lowest input index wins, and the block raises its interrupt output when the winner outranks whatever is currently in service.

The processor answers with two acknowledge pulses, each one clock cycle wide. The first pulse moves the winning request into the in-service register and lowers the interrupt output. During the second pulse the block drives a type number onto the data bus. That number is the programmed base in the upper five bits and the winner's index in the lower three.

A request that outranks the current service level raises the interrupt output again, so service can nest. Requests of equal or lower rank wait until an end-of-interrupt command clears the in-service bit that blocks them. A small write port loads the mask register and the base vector, and it issues both non-specific and specific end-of-interrupt commands.

Top module: `pic_top`

## Requirements
- R1: After reset, intOut and dataEn are low, every mask bit is set (all inputs masked), the base vector is zero and no input is in service.
- R2: A request whose mask bit is 1 never raises intOut. Writing the mask register (wrAddr 0, bit n masks input n) takes effect at run time, and clearing the bit lets the held request raise intOut.
- R3: Fixed priority applies: among unmasked pending requests, input 0 ranks highest and input 7 lowest, and the lowest index is the one served.
- R4: During the second acknowledge pulse, dataEn is high and dataOut equals {base[7:3], index}, where base is loaded by a write to wrAddr 1 (only bits 7:3 are kept). At all other times dataEn is low and dataOut is zero.
- R5: The first acknowledge pulse sets the winner's in-service bit and drops intOut. While the handshake is open, intOut stays low.
- R6: While an input is in service, requests of equal or lower priority (equal or higher index) do not raise intOut.
- R7: A request of higher priority than the highest in-service input raises intOut, and it can be acknowledged, which nests its service.
- R8: A write to wrAddr 2 with bit 7 clear (non-specific end-of-interrupt) clears the highest-priority bit that is set in the in-service register.
- R9: A write to wrAddr 2 with bit 7 set (specific end-of-interrupt) clears only the in-service bit whose index is in bits 2:0.
- R10: Inputs are level-sensitive. If a request falls before the first acknowledge pulse, that pulse sets no in-service bit, and the second pulse returns the index of input 7 as the lowest-priority default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 8 | Level-sensitive request lines, bit n is input n |
| intAck | input | 1 | Acknowledge pulse from the processor, one cycle per pulse |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 mask, 1 base vector, 2 end-of-interrupt |
| wrData | input | 8 | Write data |
| intOut | output | 1 | Interrupt request to the processor |
| dataEn | output | 1 | Data bus drive enable, high during the second acknowledge pulse |
| dataOut | output | 8 | Type number returned to the processor |

## Verification
The in-service register cannot be read, so a wrong in-service state shows only at intOut. A bit set that should have been cleared blocks a request that ought to interrupt. A bit cleared that should have stayed set lets an equal-priority request interrupt again. Either fault appears two clock edges after the request or command that exposes it. The bench therefore follows every grant and end-of-interrupt command with a request whose outcome depends on the exact in-service contents. It also checks the returned type number on every second pulse, which exposes a wrong captured index or base in the same cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;

  localparam logic [1:0] ADDR_MASK = 2'd0;
  localparam logic [1:0] ADDR_BASE = 2'd1;
  localparam logic [1:0] ADDR_EOI  = 2'd2;

  typedef enum logic {
    ACK_IDLE  = 1'b0,
    ACK_WAIT2 = 1'b1
  } ackState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic grant;     // first acknowledge pulse
    logic sendVec;   // second acknowledge pulse
    logic eoiAny;    // non-specific end-of-interrupt
    logic eoiOne;    // specific end-of-interrupt
    logic loadMask;
    logic loadBase;
  } picStrobe_t;

endpackage

// File: rtl/pic_datapath.sv
module pic_datapath
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_IRQ-1:0]  irqIn,
  input  picStrobe_t          strobe,
  input  logic [VEC_W-1:0]    wrData,
  output logic                eligible,
  output logic [VEC_W-1:0]    vecOut,
  output logic [NUM_IRQ-1:0]  isrBits
);

  localparam int IDX_W  = $clog2(NUM_IRQ);
  localparam int BASE_W = VEC_W - IDX_W;
  localparam logic [IDX_W-1:0] LOWEST_IDX = IDX_W'(NUM_IRQ - 1);

  logic [NUM_IRQ-1:0] reqReg;
  logic [NUM_IRQ-1:0] maskReg;
  logic [NUM_IRQ-1:0] isrReg;
  logic [BASE_W-1:0]  baseReg;
  logic [IDX_W-1:0]   grantIdx;

  logic [NUM_IRQ-1:0] pending;
  logic               winValid;
  logic [IDX_W-1:0]   winIdx;
  logic               srvValid;
  logic [IDX_W-1:0]   srvIdx;
  logic [NUM_IRQ-1:0] grantSet;
  logic [NUM_IRQ-1:0] eoiClr;
  logic [IDX_W-1:0]   eoiSel;

  // Lowest set index of a vector; index 0 has the highest priority
  function automatic logic [IDX_W:0] firstSet(input logic [NUM_IRQ-1:0] bits);
    logic [IDX_W:0] res;
    res = '0;
    for (int k = NUM_IRQ - 1; k >= 0; k--) begin
      if (bits[k]) res = {1'b1, IDX_W'(k)};
    end
    return res;
  endfunction

  assign pending = reqReg & ~maskReg;
  assign {winValid, winIdx} = firstSet(pending);
  assign {srvValid, srvIdx} = firstSet(isrReg);

  // Forwarded only if it outranks every input currently in service
  assign eligible = winValid && (!srvValid || (winIdx < srvIdx));

  assign eoiSel = wrData[IDX_W-1:0];

  generate
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
      assign grantSet[g] = strobe.grant && eligible && (winIdx == IDX_W'(g));
      assign eoiClr[g]   = (strobe.eoiAny && srvValid && (srvIdx == IDX_W'(g)))
                         || (strobe.eoiOne && (eoiSel == IDX_W'(g)));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqReg <= '0;
    end else begin
      reqReg <= irqIn & ~grantSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '1;
      baseReg <= '0;
    end else begin
      if (strobe.loadMask) maskReg <= wrData[NUM_IRQ-1:0];
      if (strobe.loadBase) baseReg <= wrData[VEC_W-1:IDX_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrReg <= '0;
    end else begin
      isrReg <= (isrReg & ~eoiClr) | grantSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantIdx <= '0;
    end else if (strobe.grant) begin
      grantIdx <= eligible ? winIdx : LOWEST_IDX;
    end
  end

  assign vecOut  = {baseReg, grantIdx};
  assign isrBits = isrReg;

endmodule

// File: rtl/pic_control.sv
module pic_control
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       intAck,
  input  logic       wrEn,
  input  logic [1:0] wrAddr,
  input  logic       eoiSpecific,
  input  logic       eligible,
  output picStrobe_t strobe,
  output logic       intOut,
  output logic       dataEn,
  output logic       ackBusy
);

  ackState_e state;
  ackState_e stateNext;

  always_comb begin
    strobe          = '0;
    strobe.grant    = intAck && (state == ACK_IDLE);
    strobe.sendVec  = intAck && (state == ACK_WAIT2);
    strobe.loadMask = wrEn && (wrAddr == ADDR_MASK);
    strobe.loadBase = wrEn && (wrAddr == ADDR_BASE);
    strobe.eoiAny   = wrEn && (wrAddr == ADDR_EOI) && !eoiSpecific;
    strobe.eoiOne   = wrEn && (wrAddr == ADDR_EOI) && eoiSpecific;
  end

  always_comb begin
    stateNext = state;
    if (strobe.grant)   stateNext = ACK_WAIT2;
    if (strobe.sendVec) stateNext = ACK_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ACK_IDLE;
      intOut <= 1'b0;
    end else begin
      state  <= stateNext;
      intOut <= eligible && !strobe.grant && (stateNext == ACK_IDLE);
    end
  end

  assign dataEn  = strobe.sendVec;
  assign ackBusy = (state == ACK_WAIT2);

endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int VEC_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqIn,
  input  logic               intAck,
  input  logic               wrEn,
  input  logic [1:0]         wrAddr,
  input  logic [VEC_W-1:0]   wrData,
  output logic               intOut,
  output logic               dataEn,
  output logic [VEC_W-1:0]   dataOut
);

  picStrobe_t         strobe;
  logic               eligible;
  logic [VEC_W-1:0]   vecOut;
  logic [NUM_IRQ-1:0] isrBits;
  logic               ackBusy;

  pic_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .intAck     (intAck),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .eoiSpecific(wrData[VEC_W-1]),
    .eligible   (eligible),
    .strobe     (strobe),
    .intOut     (intOut),
    .dataEn     (dataEn),
    .ackBusy    (ackBusy)
  );

  pic_datapath #(
    .NUM_IRQ(NUM_IRQ),
    .VEC_W  (VEC_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqIn   (irqIn),
    .strobe  (strobe),
    .wrData  (wrData),
    .eligible(eligible),
    .vecOut  (vecOut),
    .isrBits (isrBits)
  );

  assign dataOut = dataEn ? vecOut : '0;

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               intAck,
  input logic               intOut,
  input logic               dataEn,
  input logic               wrEn,
  input logic [1:0]         wrAddr,
  input logic [NUM_IRQ-1:0] isrBits,
  input logic               ackBusy
);

  p_drop_on_first_ack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !ackBusy) |=> !intOut);

  p_quiet_while_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    ackBusy |-> !intOut);

  p_isr_set_on_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(intAck && !ackBusy) |=> ((isrBits & ~$past(isrBits)) == '0));

  p_grant_single_bit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !ackBusy) |=> ($countones(isrBits & ~$past(isrBits)) <= 1));

  p_vec_on_second_r4: assert property (@(posedge clk) disable iff (!rstN)
    dataEn |-> (intAck && ackBusy));

  p_eoi_shrinks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr == 2'd2) && !(intAck && !ackBusy))
      |=> ($countones(isrBits) <= $countones($past(isrBits))));

endmodule

bind pic_top pic_checker #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .intAck (intAck),
  .intOut (intOut),
  .dataEn (dataEn),
  .wrEn   (wrEn),
  .wrAddr (wrAddr),
  .isrBits(isrBits),
  .ackBusy(ackBusy)
);

// File: tb/tb_pic_top.sv
module tb_pic_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       intAck = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       intOut;
  logic       dataEn;
  logic [7:0] dataOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] base = '0;

  always #4 clk = ~clk;

  pic_top dut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .intAck(intAck),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .intOut(intOut), .dataEn(dataEn), .dataOut(dataOut)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  // Two acknowledge pulses; returns the value seen on the second one
  task automatic ackPair(output logic en2, output logic [7:0] vec, output logic en1);
    @(negedge clk);
    intAck = 1'b1;
    #1 en1 = dataEn;
    @(negedge clk);
    intAck = 1'b0;
    @(negedge clk);
    intAck = 1'b1;
    #1 begin en2 = dataEn; vec = dataOut; end
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic serve(input int idx, input string tag);
    logic en1, en2;
    logic [7:0] vec, expv;
    expv = (base & 8'hF8) | 8'(idx);
    ackPair(en2, vec, en1);
    check(!en1, {tag, " dataEn low on first pulse (R4)"}, int'(en1), 0);
    check(en2 && vec == expv, {tag, " vector on second pulse (R4)"}, int'(vec), int'(expv));
    check(dataEn == 1'b0 && dataOut == 8'h00, {tag, " bus idle after (R4)"}, int'(dataOut), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic en1, en2;
    logic [7:0] vec;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(intOut == 1'b0, "R1 intOut after reset", int'(intOut), 0);
    check(dataEn == 1'b0 && dataOut == 8'h00, "R1 bus after reset", int'(dataOut), 0);
    rstN = 1'b1;
    // R1: all masked, so a request does not interrupt
    irqIn = 8'h01;
    settle();
    check(intOut == 1'b0, "R1 masked by default", int'(intOut), 0);
    irqIn = '0;
    // R1: base zero, nothing in service
    wr(2'd0, 8'h00);
    irqIn = 8'h80;
    settle();
    check(intOut == 1'b1, "R1 empty service lets input 7 in", int'(intOut), 1);
    serve(7, "R1 base zero");
    irqIn = '0;
    wr(2'd2, 8'h00);
    settle();

    // R2 mask sweep: each input masked, then unmasked at run time
    for (int i = 0; i < 8; i++) begin
      wr(2'd0, 8'(1 << i));
      irqIn = 8'(1 << i);
      settle();
      check(intOut == 1'b0, "R2 masked request", int'(intOut), 0);
      wr(2'd0, 8'h00);
      settle();
      check(intOut == 1'b1, "R2 unmask at run time", int'(intOut), 1);
      irqIn = '0;
      settle();
    end

    // Single inputs over several bases: R4 vector, R5 grant, R6 equal held, R8 EOI
    for (int b = 0; b < 4; b++) begin
      base = 8'(b * 8'h5B);
      wr(2'd1, base);
      for (int i = 0; i < 8; i++) begin
        irqIn = 8'(1 << i);
        settle();
        check(intOut == 1'b1, "R3 single request raises intOut", int'(intOut), 1);
        @(negedge clk);
        intAck = 1'b1;
        @(negedge clk);
        intAck = 1'b0;
        check(intOut == 1'b0, "R5 intOut drops after first pulse", int'(intOut), 0);
        @(negedge clk);
        check(intOut == 1'b0, "R5 intOut low while handshake open", int'(intOut), 0);
        intAck = 1'b1;
        #1 check(dataEn && dataOut == ((base & 8'hF8) | 8'(i)), "R4 vector", int'(dataOut),
                 int'((base & 8'hF8) | 8'(i)));
        @(negedge clk);
        intAck = 1'b0;
        settle();
        check(intOut == 1'b0, "R6 same input held while in service", int'(intOut), 0);
        wr(2'd2, 8'h00);
        settle();
        check(intOut == 1'b1, "R8 EOI re-enables held request", int'(intOut), 1);
        irqIn = '0;
        settle();
      end
    end
    base = 8'hA0;
    wr(2'd1, base);

    // Pairs: R3 priority and R6 lower held
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        irqIn = 8'(1 << i) | 8'(1 << j);
        settle();
        serve(i, "R3 higher of two wins");
        settle();
        check(intOut == 1'b0, "R6 lower held while higher served", int'(intOut), 0);
        irqIn = 8'(1 << j);
        wr(2'd2, 8'h00);
        settle();
        check(intOut == 1'b1, "R8 lower released by EOI", int'(intOut), 1);
        serve(j, "R3 lower served second");
        irqIn = '0;
        wr(2'd2, 8'h00);
        settle();
      end
    end

    // Nesting: R7, R8 and R9
    for (int i = 0; i < 8; i++) begin
      for (int j = i + 1; j < 8; j++) begin
        irqIn = 8'(1 << j);
        settle();
        serve(j, "R7 outer");
        irqIn = 8'(1 << i) | 8'(1 << j);
        settle();
        check(intOut == 1'b1, "R7 higher nests over service", int'(intOut), 1);
        serve(i, "R7 nested");
        // Specific EOI on the outer input; inner still in service holds both
        wr(2'd2, 8'h80 | 8'(j));
        settle();
        check(intOut == 1'b0, "R9 specific EOI leaves inner in service", int'(intOut), 0);
        irqIn = 8'(1 << j);
        wr(2'd2, 8'h00);
        settle();
        check(intOut == 1'b1, "R8 non-specific EOI clears inner", int'(intOut), 1);
        irqIn = '0;
        settle();
      end
    end

    // Non-specific EOI picks the highest in-service bit
    irqIn = 8'h40;
    settle();
    serve(6, "R8 outer");
    irqIn = 8'h48;
    settle();
    serve(3, "R8 inner");
    wr(2'd2, 8'h00);
    settle();
    check(intOut == 1'b1, "R8 clears highest only, 3 re-eligible", int'(intOut), 1);
    irqIn = 8'h40;
    settle();
    check(intOut == 1'b0, "R8 input 6 still in service", int'(intOut), 0);
    irqIn = '0;
    wr(2'd2, 8'h00);
    settle();

    // R10: request dropped before the first pulse
    irqIn = 8'h04;
    settle();
    check(intOut == 1'b1, "R10 request seen", int'(intOut), 1);
    irqIn = '0;
    @(negedge clk);
    ackPair(en2, vec, en1);
    check(en2 && vec == ((base & 8'hF8) | 8'h07), "R10 default vector", int'(vec),
          int'((base & 8'hF8) | 8'h07));
    irqIn = 8'h20;
    settle();
    check(intOut == 1'b1, "R10 nothing put in service", int'(intOut), 1);
    irqIn = '0;
    settle();
    check(intOut == 1'b0, "R10 level drop clears intOut", int'(intOut), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule